// File: doc/BRIEF.md
# Boot Image Header Validator

Before a processor is released to run firmware from a byte-addressable memory, this block checks that the image is usable. A one-cycle start pulse begins the check. The block first reads a six-byte header. The header gives the image length, the entry program-counter value, a stored checksum byte and a boot-option byte.

The block then reads the image again from address zero up to the length in the header. It adds every byte into an 8-bit sum, except the stored checksum byte. The stored byte must bring that sum to zero modulo 256.

The boot-option byte gives three things: a clock-frequency code, a request to set up the serial debug port, and a request to force recovery. When the check ends, a one-cycle done strobe marks that the outputs are ready. The outputs are the valid flag, the recovery request, the debug-serial request, the clock code and the entry PC. They hold their values until the next accepted start.

Top module: `boot_hdr_check`

## Requirements
- R1: The 16-bit image size is read little-endian, with its low byte at offset 0 and its high byte at offset 1. The checksum covers exactly offsets 0 through size−1, so a byte at an offset of size or above has no effect on the result.
- R2: The byte at offset 4 is the stored checksum and is left out of the sum. The header is valid only when the 8-bit sum of the covered bytes plus the stored byte is 0 modulo 256.
- R3: `entry_pc_o` reports the 16-bit entry value exactly as stored, with its low byte at offset 2 and its high byte at offset 3.
- R4: The boot-option byte sits at offset 5. Its bits 5:3 form the clock code, which is reported on `clk_sel_o`. The codes are 0 = 4 MHz, 1 = 8 MHz, 2 = 16 MHz and 3 = 20 MHz.
- R5: A clock code of 4 to 7 is reserved and makes the header invalid, whatever the checksum.
- R6: `dbg_serial_o` equals bit 1 of the boot-option byte.
- R7: `recovery_o` is 1 when the header is invalid or when bit 2 of the boot-option byte is set. Bit 2 therefore forces recovery even when the header is valid.
- R8: Bits 7:6 of the boot-option byte have no effect on any output.
- R9: An image size smaller than 5 makes the header invalid and requests recovery.
- R10: Each start accepted while idle produces exactly one single-cycle `done_o` pulse. A start while busy is ignored. The results stay unchanged from the done pulse until the next accepted start.
- R11: Memory reads are issued only while `busy_o` is high. Each read returns its data one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; all outputs 0 |
| start_i | input | 1 | Begin a validation pass (honoured only while idle) |
| mem_rd_en_o | output | 1 | Memory read request |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_data_i | input | 8 | Read data, valid the cycle after the request |
| busy_o | output | 1 | Validation in progress |
| done_o | output | 1 | One-cycle strobe: results ready |
| hdr_valid_o | output | 1 | Header and checksum good |
| recovery_o | output | 1 | Recovery mode requested |
| dbg_serial_o | output | 1 | Configure serial debug port before boot |
| clk_sel_o | output | 3 | Clock-frequency code |
| entry_pc_o | output | 16 | Entry program-counter value |

## Verification
The bench runs the check on the following images:
- A correctly summed image, which shows that the sum and the exclusion of offset 4 match.
- The same image with one covered byte corrupted, which shows that every covered byte takes part in the sum.
- An image with a byte corrupted just past its size, which shows that the length field bounds the sum.
- Sizes of exactly 5 and of 4, which separate the smallest legal image from a rejected one.
- Boot-option bytes with a reserved clock code, with the force bit set, and with the reserved top bits set. These separate the three ways the option byte can change the outcome.
- A start pulse sent while the block is busy, which checks that it produces no second result.

// File: rtl/boot_hdr_pkg.sv
package boot_hdr_pkg;

  localparam int HDR_BYTES   = 6;
  localparam int OFF_SIZE_LO = 0;
  localparam int OFF_SIZE_HI = 1;
  localparam int OFF_PC_LO   = 2;
  localparam int OFF_PC_HI   = 3;
  localparam int OFF_CSUM    = 4;
  localparam int OFF_OPT     = 5;
  localparam int MIN_IMAGE   = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_SUM,
    ST_CMP,
    ST_DONE
  } vstate_t;

  // running modulo-256 accumulation
  function automatic logic [7:0] sum_add(input logic [7:0] acc, input logic [7:0] b);
    return acc + b;
  endfunction

  // stored byte closes the sum to zero
  function automatic logic sum_closes(input logic [7:0] acc, input logic [7:0] stored);
    logic [7:0] t;
    t = acc + stored;
    return (t == 8'h00);
  endfunction

  function automatic logic clk_code_legal(input logic [2:0] code);
    return (code <= 3'd3);
  endfunction

endpackage

// File: rtl/boot_hdr_fetch.sv
module boot_hdr_fetch #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch_i,
  input  logic [AW-1:0] last_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          rsp_vld_o,
  output logic [AW-1:0] rsp_addr_o,
  output logic          rsp_last_o
);

  logic [AW-1:0] cur_q;
  logic [AW-1:0] last_q;
  logic          act_q;
  logic          at_end;

  assign at_end    = (cur_q == last_q);
  assign rd_en_o   = act_q;
  assign rd_addr_o = cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q      <= '0;
      last_q     <= '0;
      act_q      <= 1'b0;
      rsp_vld_o  <= 1'b0;
      rsp_addr_o <= '0;
      rsp_last_o <= 1'b0;
    end else begin
      rsp_vld_o  <= act_q;
      rsp_addr_o <= cur_q;
      rsp_last_o <= act_q && at_end;
      if (launch_i) begin
        cur_q  <= '0;
        last_q <= last_i;
        act_q  <= 1'b1;
      end else if (act_q) begin
        if (at_end) act_q <= 1'b0;
        else        cur_q <= cur_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/boot_hdr_accum.sv
module boot_hdr_accum (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic       add_i,
  input  logic [7:0] byte_i,
  output logic [7:0] sum_o
);
  import boot_hdr_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) sum_o <= 8'h00;
    else if (add_i)        sum_o <= sum_add(sum_o, byte_i);
  end

endmodule

// File: rtl/boot_hdr_optdec.sv
module boot_hdr_optdec (
  input  logic [4:0] opt_i,       // boot-option bits 5:1
  output logic [2:0] clk_code_o,
  output logic       code_ok_o,
  output logic       dbg_en_o,
  output logic       force_rec_o
);
  import boot_hdr_pkg::*;

  assign clk_code_o  = opt_i[4:2];
  assign force_rec_o = opt_i[1];
  assign dbg_en_o    = opt_i[0];
  assign code_ok_o   = clk_code_legal(opt_i[4:2]);

endmodule

// File: rtl/boot_hdr_check.sv
module boot_hdr_check #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              mem_rd_en_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              hdr_valid_o,
  output logic              recovery_o,
  output logic              dbg_serial_o,
  output logic [2:0]        clk_sel_o,
  output logic [15:0]       entry_pc_o
);
  import boot_hdr_pkg::*;

  localparam logic [ADDR_W-1:0] HDR_LAST = ADDR_W'(HDR_BYTES - 1);
  localparam logic [ADDR_W-1:0] A_CSUM   = ADDR_W'(OFF_CSUM);

  vstate_t           state_q;
  logic [15:0]       size_q;
  logic [15:0]       pc_q;
  logic [7:0]        stored_q;
  logic [4:0]        opt_q;

  // named internal events
  logic              accept_start;
  logic              hdr_done;
  logic              sum_done;
  logic              launch;
  logic [ADDR_W-1:0] launch_last;
  logic              add_byte;
  logic              size_ok;
  logic              code_ok;
  logic              sum_ok;
  logic              verdict;

  logic              rsp_vld;
  logic [ADDR_W-1:0] rsp_addr;
  logic              rsp_last;
  logic [7:0]        sum;
  logic [2:0]        clk_code;
  logic              dbg_en;
  logic              force_rec;

  assign accept_start = (state_q == ST_IDLE) && start_i;
  assign hdr_done     = (state_q == ST_HDR) && rsp_vld && rsp_last;
  assign sum_done     = (state_q == ST_SUM) && rsp_vld && rsp_last;
  assign size_ok      = (size_q >= 16'(MIN_IMAGE));
  assign launch       = accept_start || (hdr_done && size_ok);
  assign launch_last  = accept_start ? HDR_LAST : ADDR_W'(size_q - 16'd1);
  assign add_byte     = (state_q == ST_SUM) && rsp_vld && (rsp_addr != A_CSUM);
  assign sum_ok       = sum_closes(sum, stored_q);
  assign verdict      = size_ok && code_ok && sum_ok;

  assign busy_o = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done_o = (state_q == ST_DONE);

  boot_hdr_fetch #(.AW(ADDR_W)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch_i  (launch),
    .last_i    (launch_last),
    .rd_en_o   (mem_rd_en_o),
    .rd_addr_o (mem_addr_o),
    .rsp_vld_o (rsp_vld),
    .rsp_addr_o(rsp_addr),
    .rsp_last_o(rsp_last)
  );

  boot_hdr_accum u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear_i(accept_start),
    .add_i  (add_byte),
    .byte_i (mem_data_i),
    .sum_o  (sum)
  );

  boot_hdr_optdec u_optdec (
    .opt_i      (opt_q),
    .clk_code_o (clk_code),
    .code_ok_o  (code_ok),
    .dbg_en_o   (dbg_en),
    .force_rec_o(force_rec)
  );

  // sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i)  state_q <= ST_HDR;
        ST_HDR:  if (hdr_done) state_q <= size_ok ? ST_SUM : ST_CMP;
        ST_SUM:  if (sum_done) state_q <= ST_CMP;
        ST_CMP:                state_q <= ST_DONE;
        ST_DONE:               state_q <= ST_IDLE;
        default:               state_q <= ST_IDLE;
      endcase
    end
  end

  // header field capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q   <= '0;
      pc_q     <= '0;
      stored_q <= '0;
      opt_q    <= '0;
    end else if ((state_q == ST_HDR) && rsp_vld) begin
      if (rsp_addr == ADDR_W'(OFF_SIZE_LO)) size_q[7:0]  <= mem_data_i;
      if (rsp_addr == ADDR_W'(OFF_SIZE_HI)) size_q[15:8] <= mem_data_i;
      if (rsp_addr == ADDR_W'(OFF_PC_LO))   pc_q[7:0]    <= mem_data_i;
      if (rsp_addr == ADDR_W'(OFF_PC_HI))   pc_q[15:8]   <= mem_data_i;
      if (rsp_addr == A_CSUM)               stored_q     <= mem_data_i;
      if (rsp_addr == ADDR_W'(OFF_OPT))     opt_q        <= mem_data_i[5:1];
    end
  end

  // result registers, written once per pass
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_valid_o  <= 1'b0;
      recovery_o   <= 1'b0;
      dbg_serial_o <= 1'b0;
      clk_sel_o    <= '0;
      entry_pc_o   <= '0;
    end else if (state_q == ST_CMP) begin
      hdr_valid_o  <= verdict;
      recovery_o   <= !verdict || force_rec;
      dbg_serial_o <= dbg_en;
      clk_sel_o    <= clk_code;
      entry_pc_o   <= pc_q;
    end
  end

endmodule

// File: rtl/boot_hdr_check_sva.sv
module boot_hdr_check_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        mem_rd_en_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        hdr_valid_o,
  input logic        recovery_o,
  input logic [2:0]  clk_sel_o,
  input logic [15:0] entry_pc_o,
  input logic        size_ok
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);  // R10

  AST_DONE_AFTER_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(busy_o));  // R10

  AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(hdr_valid_o) && $stable(recovery_o) && $stable(entry_pc_o)));  // R10

  AST_READ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en_o |-> busy_o);  // R11

  AST_INVALID_RECOVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !hdr_valid_o) |-> recovery_o);  // R7

  AST_RESERVED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && clk_sel_o[2]) |-> !hdr_valid_o);  // R5

  AST_SMALL_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !size_ok) |-> (!hdr_valid_o && recovery_o));  // R9

endmodule

bind boot_hdr_check boot_hdr_check_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .mem_rd_en_o(mem_rd_en_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .hdr_valid_o(hdr_valid_o),
  .recovery_o (recovery_o),
  .clk_sel_o  (clk_sel_o),
  .entry_pc_o (entry_pc_o),
  .size_ok    (size_ok)
);

// File: tb/test_boot_hdr_check.sv
module test_boot_hdr_check;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          mem_rd_en_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0]    mem_data_i = 8'h00;
  logic          busy_o, done_o, hdr_valid_o, recovery_o, dbg_serial_o;
  logic [2:0]    clk_sel_o;
  logic [15:0]   entry_pc_o;

  int checks = 0;
  int errors = 0;
  int dones  = 0;
  int starts = 0;

  logic [7:0] mem [1024];

  typedef struct {
    bit        valid;
    bit        rec;
    bit        dbg;
    bit [2:0]  code;
    bit [15:0] pc;
    string     tag;
  } exp_t;

  exp_t q[$];
  exp_t last_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_hdr_check #(.ADDR_W(AW)) i_boot_hdr_check (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .mem_rd_en_o(mem_rd_en_o), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
    .busy_o(busy_o), .done_o(done_o), .hdr_valid_o(hdr_valid_o),
    .recovery_o(recovery_o), .dbg_serial_o(dbg_serial_o),
    .clk_sel_o(clk_sel_o), .entry_pc_o(entry_pc_o)
  );

  // memory model, one cycle read latency
  always @(posedge clk) if (mem_rd_en_o) mem_data_i <= mem[mem_addr_o[9:0]];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // fill an image; the stored byte is chosen so the covered sum closes
  task automatic build(input int size, input bit [15:0] pc, input bit [7:0] opt);
    bit [7:0] s;
    for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);
    mem[0] = size[7:0];
    mem[1] = size[15:8];
    mem[2] = pc[7:0];
    mem[3] = pc[15:8];
    mem[5] = opt;
    s = 8'h00;
    for (int i = 0; i < size; i++) if (i != 4) s = s + mem[i];
    mem[4] = 8'h00 - s;
  endtask

  // reference outcome written from the requirements
  function automatic exp_t predict(input string tag);
    exp_t e;
    int size;
    int total;
    bit [2:0] code;
    size = {mem[1], mem[0]};
    total = mem[4];
    for (int i = 0; i < size; i++) if (i != 4) total += mem[i];
    code = mem[5][5:3];
    e.valid = (size >= 5) && (code < 4) && ((total % 256) == 0);
    e.rec   = !e.valid || mem[5][2];
    e.dbg   = mem[5][1];
    e.code  = code;
    e.pc    = {mem[3], mem[2]};
    e.tag   = tag;
    return e;
  endfunction

  task automatic run(input string tag);
    q.push_back(predict(tag));
    @(negedge clk); start_i = 1'b1; starts++;
    @(negedge clk); start_i = 1'b0;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (done_o) begin
        dones++;
        if (q.size() == 0) begin
          chk(1'b0, "R10", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          last_exp = e;
          chk(hdr_valid_o == e.valid, e.tag, "valid", hdr_valid_o, e.valid);
          chk(recovery_o == e.rec, "R7", {e.tag, " recovery"}, recovery_o, e.rec);
          chk(dbg_serial_o == e.dbg, "R6", {e.tag, " dbg"}, dbg_serial_o, e.dbg);
          chk(clk_sel_o == e.code, "R4", {e.tag, " clk code"}, clk_sel_o, e.code);
          chk(entry_pc_o == e.pc, "R3", {e.tag, " entry pc"}, entry_pc_o, e.pc);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !mem_rd_en_o && !hdr_valid_o && !recovery_o && entry_pc_o == 0,
        "R10", "reset state", {busy_o, done_o, mem_rd_en_o, hdr_valid_o, recovery_o}, 0);

    // R1 R2: good image, option code 2, debug on
    build(32, 16'h1234, 8'b00_010_010);
    run("R2 good");
    // R2: corrupt one covered byte
    build(40, 16'hbeef, 8'b00_001_000);
    mem[20] = mem[20] ^ 8'h5a;
    run("R2 corrupt");
    // R1: byte past the size has no effect
    build(24, 16'h0100, 8'b00_011_000);
    mem[24] = mem[24] ^ 8'hff;
    mem[100] = mem[100] ^ 8'h11;
    run("R1 beyond size");
    // R1: little-endian size over 255
    build(600, 16'h7f02, 8'b00_000_010);
    run("R1 large size");
    // R7: force recovery with good header
    build(16, 16'h0042, 8'b00_000_100);
    run("R7 forced");
    // R5: reserved codes with good checksum
    build(16, 16'h0043, 8'b00_101_000);
    run("R5 reserved 5");
    build(20, 16'h0044, 8'b00_100_010);
    run("R5 reserved 4");
    // R8: reserved top bits set, result as if clear
    build(32, 16'h1234, 8'b11_010_010);
    run("R8 top bits");
    chk(hdr_valid_o == 1'b1 && clk_sel_o == 3'd2, "R8", "top bits ignored",
        {hdr_valid_o, clk_sel_o}, {1'b1, 3'd2});
    // R9: size 5 minimum legal, size 4 rejected
    build(5, 16'h0005, 8'b00_001_000);
    run("R9 size5");
    build(4, 16'h0004, 8'b00_001_000);
    run("R9 size4");
    build(0, 16'h0000, 8'b00_000_000);
    run("R9 size0");
    // R2: stored byte altered breaks the check
    build(12, 16'h0abc, 8'b00_000_000);
    mem[4] = mem[4] + 8'h01;
    run("R2 stored off");

    // R10: start while busy is ignored; results held afterwards
    build(64, 16'h4321, 8'b00_001_010);
    q.push_back(predict("R10 busy start"));
    @(negedge clk); start_i = 1'b1; starts++;
    @(negedge clk); start_i = 1'b0;
    repeat (5) @(negedge clk);
    chk(busy_o == 1'b1, "R10", "busy during pass", busy_o, 1);
    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (100) @(negedge clk);
    chk(dones == starts, "R10", "one done per accepted start", dones, starts);
    chk(hdr_valid_o == last_exp.valid && entry_pc_o == last_exp.pc, "R10", "results held",
        entry_pc_o, last_exp.pc);
    chk(!busy_o && !mem_rd_en_o, "R11", "no reads while idle", mem_rd_en_o, 0);
    summary();
  end

endmodule